// File: doc/BRIEF.md
# USB Endpoint Receive Status Register

This block holds the receive-side control state of a single USB device endpoint. It stores four items: a transfer-complete flag, the expected data toggle for the next packet, a two-bit receive handshake status, and an indicator that records whether the last accepted transaction was a SETUP. Software changes the register through a write strobe and data word, and it sees the current value at all times on a read bus. Each field has its own write rule. The transfer-complete flag can only be cleared, and only by writing 0. The toggle bit and the status field invert where a 1 is written. The SETUP indicator cannot be written.

The USB transaction engine reports into the block. It gives a one-cycle pulse when a SETUP token arrives, and a one-cycle pulse at the end of each receive transaction. With the end-of-transaction pulse it gives the token kind, the handshake it returned, the data PID it received and an error flag. The endpoint type decides how the block responds. Isochronous endpoints use no handshake, and their status is never changed by hardware. Control endpoints clear the toggle when a SETUP token arrives, and only control endpoints update the SETUP indicator. A registered interrupt follows the transfer-complete flag, gated by an enable input.

Encodings used at the ports:
- Endpoint type: 00 = bulk, 01 = control, 10 = isochronous, 11 = interrupt.
- Handshake: 00 = ACK, 01 = NAK, 10 = STALL, 11 = none.
- Receive status: 00 = disabled, 01 = stall, 10 = NAK, 11 = valid.

Top module: `usb_ep_rx_status`

## Requirements
- R1: While reset is high, and after it is released, `rd_data` reads all zeros and `irq` is 0. Status 00 means disabled.
- R2: The transfer-complete flag (bit 0 of `rd_data`) is set on an `ev_valid` cycle with `ev_err`=0 in either of these cases: the endpoint is isochronous, or the endpoint is not isochronous, the handshake is ACK (00) and `ev_pid` equals the stored toggle.
- R3: A receive with handshake NAK (01) or STALL (10), with `ev_err`=1, or with a PID that does not match the toggle on a non-isochronous endpoint changes no bit of `rd_data`.
- R4: A software write with bit 0 = 0 clears the transfer-complete flag. A write with bit 0 = 1 leaves the flag unchanged.
- R5: On a non-isochronous endpoint, an accepted receive (R2) inverts the toggle bit (bit 1). The toggle holds 0 for DATA0 and 1 for DATA1.
- R6: On a control endpoint, a `tok_setup` pulse clears the toggle bit. This clear takes priority over every other toggle change in that cycle.
- R7: On an isochronous endpoint, every receive with `ev_err`=0 inverts the toggle, whatever `ev_hs` and `ev_pid` are. The status field is left unchanged.
- R8: In a software write, a 1 in bit 1, bit 2 or bit 3 inverts that bit and a 0 leaves it unchanged. Bit 4 (the SETUP indicator) cannot be written.
- R9: On a non-isochronous endpoint, an accepted receive sets the status (bits 3:2) to NAK (10). This takes priority over a software status write in the same cycle.
- R10: On an accepted receive on a control endpoint, the SETUP indicator (bit 4) takes the value of `ev_setup`. The indicator does not change when the flag was already 1 before that cycle, and it never changes on other endpoint types.
- R11: `irq` is registered. After each clock edge it equals the new flag value ANDed with the value `irq_en` had at that edge.
- R12: If a hardware set and a software clear of the flag arrive in the same cycle, the flag ends up 1. In the same cycle the toggle receives both inversions: the one from hardware and the one from software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | DATA_W | Software write data |
| tok_setup | input | 1 | SETUP token received (pulse) |
| ev_valid | input | 1 | End of a receive transaction (pulse) |
| ev_setup | input | 1 | The transaction's token was SETUP |
| ev_hs | input | 2 | Handshake returned by the engine |
| ev_pid | input | 1 | Received data PID (0 = DATA0, 1 = DATA1) |
| ev_err | input | 1 | Protocol or CRC error in the transaction |
| ep_type | input | 2 | Endpoint type |
| irq_en | input | 1 | Interrupt enable for the transfer-complete flag |
| rd_data | output | DATA_W | Current register value |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Every field is a flop that drives `rd_data` directly. A wrong update therefore shows on the read bus one edge after the event or write that caused it. There is one exception: a toggle that holds the wrong value may look harmless until the next receive. The bench covers that case by checking that a later DATA packet with the correct PID is accepted and one with the wrong PID is rejected. The frozen SETUP indicator, the collision rules and the interrupt gating are each checked on the cycle right after the stimulus.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

  typedef enum logic [1:0] {
    RXS_OFF   = 2'b00,
    RXS_STALL = 2'b01,
    RXS_NAK   = 2'b10,
    RXS_VALID = 2'b11
  } rx_stat_e;

  typedef enum logic [1:0] {
    EP_BULK = 2'b00,
    EP_CTRL = 2'b01,
    EP_ISO  = 2'b10,
    EP_INTR = 2'b11
  } ep_kind_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10,
    HS_NONE  = 2'b11
  } hs_e;

  // bit positions inside the register word
  localparam int unsigned FLD_DONE  = 0;
  localparam int unsigned FLD_TOG   = 1;
  localparam int unsigned FLD_ST_LO = 2;
  localparam int unsigned FLD_ST_HI = 3;
  localparam int unsigned FLD_SETUP = 4;
  localparam int unsigned FLD_COUNT = 5;

  typedef struct packed {
    logic done_set;
    logic tog_flip;
    logic tog_clr;
    logic force_nak;
    logic setup_load;
    logic setup_val;
  } hw_upd_t;

  typedef struct packed {
    logic       done_clr;
    logic       tog_flip;
    logic [1:0] st_flip;
  } sw_upd_t;

endpackage

// File: rtl/usb_rx_evt_decode.sv
module usb_rx_evt_decode
  import usb_rx_pkg::*;
(
  input  logic       tok_setup,
  input  logic       ev_valid,
  input  logic       ev_setup,
  input  logic [1:0] ev_hs,
  input  logic       ev_pid,
  input  logic       ev_err,
  input  logic [1:0] ep_type,
  input  logic       cur_tog,
  input  logic       cur_done,
  output hw_upd_t    upd
);

  logic is_iso;
  logic is_ctrl;
  logic pid_ok;
  logic accepted;

  always_comb begin
    is_iso   = (ep_type == EP_ISO);
    is_ctrl  = (ep_type == EP_CTRL);
    pid_ok   = (ev_pid == cur_tog);
    accepted = ev_valid && !ev_err &&
               (is_iso || ((ev_hs == HS_ACK) && pid_ok));

    upd.done_set   = accepted;
    upd.tog_flip   = accepted;
    upd.tog_clr    = tok_setup && is_ctrl;
    upd.force_nak  = accepted && !is_iso;
    upd.setup_load = accepted && is_ctrl && !cur_done;
    upd.setup_val  = ev_setup;
  end

endmodule

// File: rtl/usb_rx_wr_decode.sv
module usb_rx_wr_decode
  import usb_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  output sw_upd_t           upd
);

  always_comb begin
    upd.done_clr = sw_wr && !sw_wdata[FLD_DONE];
    upd.tog_flip = sw_wr && sw_wdata[FLD_TOG];
    upd.st_flip  = sw_wr ? sw_wdata[FLD_ST_HI:FLD_ST_LO] : 2'b00;
  end

endmodule

// File: rtl/usb_rx_state_regs.sv
module usb_rx_state_regs
  import usb_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  hw_upd_t    hw,
  input  sw_upd_t    sw,
  input  logic       irq_en,
  output logic       done_q,
  output logic       tog_q,
  output logic [1:0] st_q,
  output logic       setup_q,
  output logic       irq_q
);

  logic       done_d;
  logic       tog_d;
  logic [1:0] st_d;
  logic       setup_d;

  always_comb begin
    done_d  = hw.done_set || (done_q && !sw.done_clr);
    tog_d   = hw.tog_clr ? 1'b0 : (tog_q ^ hw.tog_flip ^ sw.tog_flip);
    st_d    = hw.force_nak ? RXS_NAK : (st_q ^ sw.st_flip);
    setup_d = hw.setup_load ? hw.setup_val : setup_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      tog_q   <= 1'b0;
      st_q    <= RXS_OFF;
      setup_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      done_q  <= done_d;
      tog_q   <= tog_d;
      st_q    <= st_d;
      setup_q <= setup_d;
      irq_q   <= done_d && irq_en;
    end
  end

endmodule

// File: rtl/usb_ep_rx_status.sv
module usb_ep_rx_status
  import usb_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              tok_setup,
  input  logic              ev_valid,
  input  logic              ev_setup,
  input  logic [1:0]        ev_hs,
  input  logic              ev_pid,
  input  logic              ev_err,
  input  logic [1:0]        ep_type,
  input  logic              irq_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  localparam int unsigned USED_W = (DATA_W < FLD_COUNT) ? DATA_W : FLD_COUNT;

  hw_upd_t    hw_upd;
  sw_upd_t    sw_upd;
  logic       done_q;
  logic       tog_q;
  logic [1:0] st_q;
  logic       setup_q;
  logic [FLD_COUNT-1:0] fields;

  usb_rx_evt_decode u_evt (
    .tok_setup (tok_setup),
    .ev_valid  (ev_valid),
    .ev_setup  (ev_setup),
    .ev_hs     (ev_hs),
    .ev_pid    (ev_pid),
    .ev_err    (ev_err),
    .ep_type   (ep_type),
    .cur_tog   (tog_q),
    .cur_done  (done_q),
    .upd       (hw_upd)
  );

  usb_rx_wr_decode #(.DATA_W(DATA_W)) u_wr (
    .sw_wr    (sw_wr),
    .sw_wdata (sw_wdata),
    .upd      (sw_upd)
  );

  usb_rx_state_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .hw      (hw_upd),
    .sw      (sw_upd),
    .irq_en  (irq_en),
    .done_q  (done_q),
    .tog_q   (tog_q),
    .st_q    (st_q),
    .setup_q (setup_q),
    .irq_q   (irq)
  );

  always_comb begin
    fields            = '0;
    fields[FLD_DONE]  = done_q;
    fields[FLD_TOG]   = tog_q;
    fields[FLD_ST_LO] = st_q[0];
    fields[FLD_ST_HI] = st_q[1];
    fields[FLD_SETUP] = setup_q;
  end

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rd
    if (gi < USED_W) begin : g_fld
      assign rd_data[gi] = fields[gi];
    end else begin : g_zero
      assign rd_data[gi] = 1'b0;
    end
  end

endmodule

// File: rtl/usb_ep_rx_status_chk.sv
module usb_ep_rx_status_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_wr,
  input logic [DATA_W-1:0] sw_wdata,
  input logic              tok_setup,
  input logic              ev_valid,
  input logic              ev_setup,
  input logic [1:0]        ev_hs,
  input logic              ev_pid,
  input logic              ev_err,
  input logic [1:0]        ep_type,
  input logic              irq_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq
);

  // R1: the cycle after reset is sampled high, everything reads zero
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == '0 && !irq));

  // R2: the flag rises only as the result of a reported transaction
  p_flag_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[0]) |-> $past(ev_valid));

  // R4: a clearing write with no transaction leaves the flag at zero
  p_sw_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (sw_wr && !sw_wdata[0] && !ev_valid) |=> !rd_data[0]);

  // R7: isochronous receives leave the status alone
  p_iso_status_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ep_type == 2'b10 && !sw_wr) |=> $stable(rd_data[3:2]));

  // R9: an accepted non-isochronous receive yields NAK
  p_force_nak_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_err && ep_type != 2'b10 && ev_hs == 2'b00 &&
     ev_pid == rd_data[1]) |=> rd_data[3:2] == 2'b10);

  // R10: indicator frozen while the flag is up
  p_setup_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    rd_data[0] |=> $stable(rd_data[4]));

  // R11: interrupt never without the flag
  p_irq_flag_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> rd_data[0]);

endmodule

bind usb_ep_rx_status usb_ep_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sw_wr     (sw_wr),
  .sw_wdata  (sw_wdata),
  .tok_setup (tok_setup),
  .ev_valid  (ev_valid),
  .ev_setup  (ev_setup),
  .ev_hs     (ev_hs),
  .ev_pid    (ev_pid),
  .ev_err    (ev_err),
  .ep_type   (ep_type),
  .irq_en    (irq_en),
  .rd_data   (rd_data),
  .irq       (irq)
);

// File: tb/usb_ep_rx_status_bench.sv
module usb_ep_rx_status_bench;

  localparam int unsigned DATA_W = 16;
  localparam logic [1:0] T_BULK = 2'b00, T_CTRL = 2'b01, T_ISO = 2'b10;
  localparam logic [1:0] H_ACK = 2'b00, H_NAK = 2'b01, H_STALL = 2'b10, H_NONE = 2'b11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sw_wr = 1'b0;
  logic [DATA_W-1:0] sw_wdata = '0;
  logic              tok_setup = 1'b0;
  logic              ev_valid = 1'b0;
  logic              ev_setup = 1'b0;
  logic [1:0]        ev_hs = 2'b00;
  logic              ev_pid = 1'b0;
  logic              ev_err = 1'b0;
  logic [1:0]        ep_type = 2'b00;
  logic              irq_en = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  usb_ep_rx_status #(.DATA_W(DATA_W)) u_usb_ep_rx_status (
    .clk, .rst, .sw_wr, .sw_wdata, .tok_setup, .ev_valid, .ev_setup,
    .ev_hs, .ev_pid, .ev_err, .ep_type, .irq_en, .rd_data, .irq
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] d);
    sw_wr = 1'b1; sw_wdata = DATA_W'(d);
    cyc();
    sw_wr = 1'b0; sw_wdata = '0;
  endtask

  task automatic ev(input logic s, input logic [1:0] h, input logic p, input logic e);
    ev_valid = 1'b1; ev_setup = s; ev_hs = h; ev_pid = p; ev_err = e;
    cyc();
    ev_valid = 1'b0; ev_setup = 1'b0; ev_hs = 2'b00; ev_pid = 1'b0; ev_err = 1'b0;
  endtask

  task automatic tok();
    tok_setup = 1'b1;
    cyc();
    tok_setup = 1'b0;
  endtask

  // rd_data layout: {setup, status[1:0], toggle, flag}
  task automatic t_reset();
    rst = 1'b1;
    cyc(); cyc();
    chk("R1 during reset", rd_data, 0);
    rst = 1'b0;
    cyc();
    chk("R1 after reset", rd_data, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_bulk_out();
    ep_type = T_BULK;
    wr(5'b01100);
    chk("R8 status flip to valid", rd_data, 32'b01100);
    ev(1'b0, H_ACK, 1'b0, 1'b0);
    chk("R2 R5 R9 accepted DATA0", rd_data, 32'b01011);
    wr(5'b00000);
    chk("R4 clear by zero", rd_data, 32'b01010);
    ev(1'b0, H_ACK, 1'b1, 1'b0);
    chk("R5 accepted DATA1", rd_data, 32'b01001);
    wr(5'b00001);
    chk("R4 one keeps flag", rd_data, 32'b01001);
    wr(5'b00000);
    chk("R4 clear again", rd_data, 32'b01000);
  endtask

  task automatic t_rejects();
    wr(5'b00100);
    chk("R8 status 10 to 11", rd_data, 32'b01100);
    ev(1'b0, H_NAK, 1'b0, 1'b0);
    chk("R3 NAK ignored", rd_data, 32'b01100);
    ev(1'b0, H_STALL, 1'b0, 1'b0);
    chk("R3 STALL ignored", rd_data, 32'b01100);
    ev(1'b0, H_ACK, 1'b0, 1'b1);
    chk("R3 error ignored", rd_data, 32'b01100);
    ev(1'b0, H_ACK, 1'b1, 1'b0);
    chk("R3 PID mismatch ignored", rd_data, 32'b01100);
  endtask

  task automatic t_control();
    ep_type = T_CTRL;
    wr(5'b00010);
    chk("R8 toggle flip", rd_data, 32'b01110);
    tok();
    chk("R6 SETUP token clears toggle", rd_data, 32'b01100);
    ev(1'b1, H_ACK, 1'b0, 1'b0);
    chk("R10 SETUP accepted", rd_data, 32'b11011);
    ev(1'b0, H_ACK, 1'b1, 1'b0);
    chk("R10 indicator frozen", rd_data, 32'b11001);
    wr(5'b00000);
    chk("R4 R10 clear keeps indicator", rd_data, 32'b11000);
    wr(5'b00100);
    ev(1'b0, H_ACK, 1'b0, 1'b0);
    chk("R10 OUT updates indicator", rd_data, 32'b01011);
    wr(5'b10000);
    chk("R8 indicator not writable", rd_data, 32'b01010);
  endtask

  task automatic t_bulk_setup();
    ep_type = T_BULK;
    ev(1'b1, H_ACK, 1'b1, 1'b0);
    chk("R10 bulk leaves indicator", rd_data, 32'b01001);
    wr(5'b00000);
    tok();
    chk("R6 token ignored on bulk", rd_data, 32'b01000);
  endtask

  task automatic t_iso();
    ep_type = T_ISO;
    wr(5'b00100);
    chk("R8 status to valid", rd_data, 32'b01100);
    ev(1'b0, H_NONE, 1'b0, 1'b0);
    chk("R7 iso receive", rd_data, 32'b01111);
    ev(1'b0, H_NONE, 1'b0, 1'b0);
    chk("R7 iso toggle again", rd_data, 32'b01101);
    ev(1'b0, H_NONE, 1'b0, 1'b1);
    chk("R3 iso error ignored", rd_data, 32'b01101);
    wr(5'b00000);
    chk("R4 iso clear", rd_data, 32'b01100);
  endtask

  task automatic t_irq();
    ep_type = T_BULK;
    irq_en = 1'b0;
    ev(1'b0, H_ACK, 1'b0, 1'b0);
    chk("R11 masked", irq, 0);
    irq_en = 1'b1;
    cyc();
    chk("R11 enabled", irq, 1);
    wr(5'b00000);
    chk("R11 cleared", irq, 0);
  endtask

  task automatic t_collision();
    // state now: toggle 1, status NAK, flag 0
    ev_valid = 1'b1; ev_hs = H_ACK; ev_pid = 1'b1;
    sw_wr = 1'b1; sw_wdata = DATA_W'(5'b00110);
    cyc();
    ev_valid = 1'b0; ev_pid = 1'b0; sw_wr = 1'b0; sw_wdata = '0;
    chk("R12 R9 hw wins, toggles combine", rd_data, 32'b01011);
    chk("R12 R11 irq", irq, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_bulk_out();
        t_rejects();
        t_control();
        t_bulk_setup();
        t_iso();
        t_irq();
        t_collision();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
      end
    join_any
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule